// File: doc/BRIEF.md
# First-Fault Capture and Interrupt Logic

This block sits beside a memory-protection checker. The checker sends it one event for each access it rejects. The block keeps a single fault record: the faulting address, the master ID, the privilege ID, the security level and a six-bit fault-kind code. Once a record is held, every later fault is discarded until software frees the record by clearing its kind field. Events that come from the debug path are never recorded.

The block also owns two interrupt sources. A protection error is raised when a fault is recorded. An address error is raised when a register access lands on an offset that has no register. Each source has a raw status bit and an enable bit. Software can force a raw bit on through a set-only register. It clears a raw bit through the enabled-status register. Enables are controlled through separate set and clear registers. The two enabled status bits are ORed into a single level interrupt.

The register port is a simple word-offset read/write port. Read data is returned combinationally in the same cycle. Only the low two write-data bits are carried, because no writable field is wider than that.

Top module: `mpu_fault_irq`

## Requirements
- R1: After a synchronous active-low reset, every readable register returns zero and `irq` is low.
- R2: An event with `flt_valid`=1, `flt_debug`=0 and a non-zero kind is recorded when the record is free. The record is free when its kind field is zero. The address is stored at offset 4. The status word at offset 5 packs master ID in bits 23..16, privilege ID in bits 12..9, the non-secure flag in bit 7 and the kind in bits 5..0, with all other bits zero. The protection raw bit is set on the same clock edge. Kind codes are 100000 supervisor read, 010000 supervisor write, 001000 supervisor execute, 000100 user read, 000010 user write, 000001 user execute, 111111 line fill and 010010 write-back. An event whose kind is 000000 is ignored.
- R3: While the record holds a non-zero kind, further events change neither offset 4 nor offset 5, and they do not set the protection raw bit.
- R4: Writing 1 to bit 0 at offset 6 clears only the kind field of offset 5, and offset 4 is kept. Writing 0 there has no effect. Offset 6 always reads zero.
- R5: An event that arrives in the same cycle as a record-clearing write to offset 6 is recorded.
- R6: Events with `flt_debug`=1 never change the record and never set a status bit.
- R7: Offset 0 reads raw status, with bit 1 for address error and bit 0 for protection error. Writing 1 to a bit there sets it, and writing 0 has no effect.
- R8: Offset 1 reads raw AND enable. Writing 1 to a bit there clears that raw bit, and writing 0 has no effect.
- R9: Writing 1 to a bit at offset 2 sets that enable, and writing 1 at offset 3 clears it. Zeros have no effect. Both offsets read the current enables.
- R10: Any non-debug read or write to an offset of 7 or above sets the address-error raw bit and reads zero. The same access made with `reg_debug`=1 leaves the status unchanged.
- R11: `irq` is the OR of the two enabled status bits. It stays high until software clears the status or removes the enable.
- R12: When a status clear at offset 1 and a hardware event for the same bit arrive in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flt_valid | input | 1 | Fault event from the checker |
| flt_debug | input | 1 | Event came from the debug path |
| flt_addr | input | ADDR_W | Faulting address |
| flt_mst | input | 8 | Master ID of the faulting access |
| flt_priv | input | 4 | Privilege ID of the faulting access |
| flt_ns | input | 1 | 1 = non-secure access |
| flt_kind | input | 6 | Fault-kind code |
| reg_en | input | 1 | Register access this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_debug | input | 1 | Register access came from the debug path |
| reg_off | input | OFF_W | Word offset of the register |
| reg_wbits | input | 2 | Low write-data bits |
| reg_rdata | output | 32 | Read data, valid in the cycle of a read |
| irq | output | 1 | Combined level interrupt |

## Verification
The capture path is driven with three kinds of event pattern:
- Lone events with different kind codes, master IDs and security flags. These separate correct field packing from shifted or truncated fields.
- Events that arrive while a record is held. These separate a true first-fault hold from a last-fault overwrite.
- Events that coincide with a record clear or a status clear. These expose which update wins inside one cycle.

The status path is exercised with write-1 and write-0 patterns on each set-only and clear-only register, and with enables toggled while status is pending. This separates the raw view from the enabled view and checks that `irq` follows the enabled view. Accesses to unmapped offsets are made from both the normal and the debug path, which shows whether the address-error source is qualified correctly.

// File: rtl/flt_pkg.sv
// Shared constants and types for the fault capture block.
// Assumes a word-offset register port and two interrupt sources.
package flt_pkg;
    localparam int MST_W       = 8;
    localparam int PRIV_W      = 4;
    localparam int KIND_W      = 6;
    localparam int DATA_W      = 32;

    // Status word field positions (decoded by software)
    localparam int ST_MST_LSB  = 16;
    localparam int ST_PRIV_LSB = 9;
    localparam int ST_NS_BIT   = 7;

    // Interrupt source indices
    localparam int NUM_SRC     = 2;
    localparam int IDX_PROT    = 0;
    localparam int IDX_ADDR    = 1;

    // Register word offsets
    localparam int OFF_RAW     = 0;
    localparam int OFF_ENSTAT  = 1;
    localparam int OFF_ENSET   = 2;
    localparam int OFF_ENCLR   = 3;
    localparam int OFF_FADDR   = 4;
    localparam int OFF_FSTAT   = 5;
    localparam int OFF_FCLR    = 6;
    localparam int NUM_REGS    = 7;

    // Fault kind codes
    localparam logic [KIND_W-1:0] KIND_NONE   = 6'b000000;
    localparam logic [KIND_W-1:0] KIND_SUP_RD = 6'b100000;
    localparam logic [KIND_W-1:0] KIND_SUP_WR = 6'b010000;
    localparam logic [KIND_W-1:0] KIND_SUP_EX = 6'b001000;
    localparam logic [KIND_W-1:0] KIND_USR_RD = 6'b000100;
    localparam logic [KIND_W-1:0] KIND_USR_WR = 6'b000010;
    localparam logic [KIND_W-1:0] KIND_USR_EX = 6'b000001;
    localparam logic [KIND_W-1:0] KIND_FILL   = 6'b111111;
    localparam logic [KIND_W-1:0] KIND_WBACK  = 6'b010010;

    typedef struct packed {
        logic [MST_W-1:0]  mst;
        logic [PRIV_W-1:0] priv;
        logic              ns;
        logic [KIND_W-1:0] kind;
    } flt_rec_t;
endpackage

// File: rtl/flt_record.sv
// Single-entry fault record. Captures the first non-debug event with a
// non-zero kind while the record is free (kind == 0). A clear request
// empties only the kind field, and it takes effect before a same-cycle capture.
// Assumes at most one event per cycle.
module flt_record
    import flt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic              ev_debug,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [MST_W-1:0]  ev_mst,
    input  logic [PRIV_W-1:0] ev_priv,
    input  logic              ev_ns,
    input  logic [KIND_W-1:0] ev_kind,
    input  logic              clr,
    output flt_rec_t          rec,
    output logic [ADDR_W-1:0] rec_addr,
    output logic              take
);
    logic busy;

    // Record is held while its kind field is non-zero
    assign busy = (rec.kind != KIND_NONE);

    // Capture decision: clear frees the record within the same cycle
    assign take = ev_valid && !ev_debug && (ev_kind != KIND_NONE) && (!busy || clr);

    // Record storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec      <= '0;
            rec_addr <= '0;
        end else if (take) begin
            rec.mst  <= ev_mst;
            rec.priv <= ev_priv;
            rec.ns   <= ev_ns;
            rec.kind <= ev_kind;
            rec_addr <= ev_addr;
        end else if (clr) begin
            rec.kind <= KIND_NONE;
        end
    end

    // R3
    rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !clr |=> $stable(rec) && $stable(rec_addr));

    // R6
    dbg_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && ev_valid && ev_debug |=> rec.kind == KIND_NONE);

    // R2
    capture_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> rec.kind == $past(ev_kind) && rec_addr == $past(ev_addr));
endmodule

// File: rtl/flt_irq_ctrl.sv
// Raw status and enable bits for each interrupt source. Hardware events and
// software set writes raise a raw bit, and a hardware event wins over a
// same-cycle software clear. Enables use separate set and clear strobes.
// Assumes set and clear strobes of one kind never arrive together.
module flt_irq_ctrl #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] en_set,
    input  logic [N-1:0] en_clr,
    output logic [N-1:0] raw,
    output logic [N-1:0] en,
    output logic         irq
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_src
            logic raw_q;
            logic en_q;

            // Raw status: set sources override a clear
            always_ff @(posedge clk) begin
                if (!rst_n) raw_q <= 1'b0;
                else        raw_q <= hw_set[i] || sw_set[i] || (raw_q && !sw_clr[i]);
            end

            // Enable bit: set-only and clear-only strobes
            always_ff @(posedge clk) begin
                if (!rst_n)         en_q <= 1'b0;
                else if (en_set[i]) en_q <= 1'b1;
                else if (en_clr[i]) en_q <= 1'b0;
            end

            assign raw[i] = raw_q;
            assign en[i]  = en_q;

            // R7
            raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sw_set[i] |=> raw[i]);

            // R8
            raw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sw_clr[i] && !hw_set[i] && !sw_set[i] |=> !raw[i]);

            // R12
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sw_clr[i] && hw_set[i] |=> raw[i]);
        end
    endgenerate

    // Combined interrupt from enabled status
    assign irq = |(raw & en);

    // R11
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && (sw_clr == '0) && (en_clr == '0) |=> irq);
endmodule

// File: rtl/flt_regdec.sv
// Register offset decode and read mux. Turns word-offset accesses into
// set and clear strobes, flags non-debug accesses to unmapped offsets,
// and returns read data in the same cycle.
// Assumes OFF_W is wide enough to hold every mapped offset.
module flt_regdec
    import flt_pkg::*;
#(
    parameter int OFF_W  = 4,
    parameter int ADDR_W = 32
) (
    input  logic               reg_en,
    input  logic               reg_we,
    input  logic               reg_debug,
    input  logic [OFF_W-1:0]   reg_off,
    input  logic [NUM_SRC-1:0] reg_wbits,
    input  logic [NUM_SRC-1:0] raw,
    input  logic [NUM_SRC-1:0] en,
    input  logic [ADDR_W-1:0]  faddr,
    input  logic [DATA_W-1:0]  fstat,
    output logic [NUM_SRC-1:0] sw_set,
    output logic [NUM_SRC-1:0] sw_clr,
    output logic [NUM_SRC-1:0] en_set,
    output logic [NUM_SRC-1:0] en_clr,
    output logic               flt_clr,
    output logic               addr_err,
    output logic [DATA_W-1:0]  rdata
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(NUM_REGS - 1);

    logic [NUM_REGS-1:0] sel;
    logic                wr;
    logic                rd;

    // One select line per mapped offset
    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
            assign sel[i] = reg_en && (reg_off == OFF_W'(i));
        end
    endgenerate

    assign wr = reg_en && reg_we;
    assign rd = reg_en && !reg_we;

    // Write strobes
    assign sw_set   = (sel[OFF_RAW]    && reg_we) ? reg_wbits : '0;
    assign sw_clr   = (sel[OFF_ENSTAT] && reg_we) ? reg_wbits : '0;
    assign en_set   = (sel[OFF_ENSET]  && reg_we) ? reg_wbits : '0;
    assign en_clr   = (sel[OFF_ENCLR]  && reg_we) ? reg_wbits : '0;
    assign flt_clr  = sel[OFF_FCLR] && wr && reg_wbits[0];

    // Unmapped offset from a non-debug master
    assign addr_err = reg_en && !reg_debug && (reg_off > LAST_OFF);

    // Read mux
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (sel[OFF_RAW])    rdata[NUM_SRC-1:0] = raw;
            if (sel[OFF_ENSTAT]) rdata[NUM_SRC-1:0] = raw & en;
            if (sel[OFF_ENSET])  rdata[NUM_SRC-1:0] = en;
            if (sel[OFF_ENCLR])  rdata[NUM_SRC-1:0] = en;
            if (sel[OFF_FADDR])  rdata[ADDR_W-1:0]  = faddr;
            if (sel[OFF_FSTAT])  rdata              = fstat;
        end
    end
endmodule

// File: rtl/mpu_fault_irq.sv
// Top of the first-fault capture and interrupt logic. Joins the record,
// the interrupt status bits and the register decode, and packs the
// fault status word.
// Assumes ADDR_W <= 32 and a single register access per cycle.
module mpu_fault_irq
    import flt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_valid,
    input  logic              flt_debug,
    input  logic [ADDR_W-1:0] flt_addr,
    input  logic [7:0]        flt_mst,
    input  logic [3:0]        flt_priv,
    input  logic              flt_ns,
    input  logic [5:0]        flt_kind,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic              reg_debug,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic [1:0]        reg_wbits,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    flt_rec_t            rec;
    logic [ADDR_W-1:0]   rec_addr;
    logic                take;
    logic                flt_clr;
    logic                addr_err;
    logic [NUM_SRC-1:0]  hw_set, sw_set, sw_clr, en_set, en_clr, raw, en;
    logic [DATA_W-1:0]   fstat;

    flt_record #(.ADDR_W(ADDR_W)) u_rec (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(flt_valid), .ev_debug(flt_debug), .ev_addr(flt_addr),
        .ev_mst(flt_mst), .ev_priv(flt_priv), .ev_ns(flt_ns), .ev_kind(flt_kind),
        .clr(flt_clr), .rec(rec), .rec_addr(rec_addr), .take(take)
    );

    // Hardware event vector per source
    always_comb begin
        hw_set           = '0;
        hw_set[IDX_PROT] = take;
        hw_set[IDX_ADDR] = addr_err;
    end

    flt_irq_ctrl #(.N(NUM_SRC)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .hw_set(hw_set), .sw_set(sw_set), .sw_clr(sw_clr),
        .en_set(en_set), .en_clr(en_clr),
        .raw(raw), .en(en), .irq(irq)
    );

    // Status word packing
    always_comb begin
        fstat                            = '0;
        fstat[ST_MST_LSB +: MST_W]       = rec.mst;
        fstat[ST_PRIV_LSB +: PRIV_W]     = rec.priv;
        fstat[ST_NS_BIT]                 = rec.ns;
        fstat[KIND_W-1:0]                = rec.kind;
    end

    flt_regdec #(.OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_dec (
        .reg_en(reg_en), .reg_we(reg_we), .reg_debug(reg_debug),
        .reg_off(reg_off), .reg_wbits(reg_wbits),
        .raw(raw), .en(en), .faddr(rec_addr), .fstat(fstat),
        .sw_set(sw_set), .sw_clr(sw_clr), .en_set(en_set), .en_clr(en_clr),
        .flt_clr(flt_clr), .addr_err(addr_err), .rdata(reg_rdata)
    );

    // R10
    addr_err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> raw[IDX_ADDR]);

    // R6
    dbg_addr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && flt_debug |=> $stable(rec_addr));

    // R5
    clr_then_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_clr && flt_valid && !flt_debug && (flt_kind != KIND_NONE) |=> raw[IDX_PROT]);
endmodule

// File: tb/tb_mpu_fault_irq.sv
module tb_mpu_fault_irq;
    localparam int OFF_W = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flt_valid, flt_debug, flt_ns;
    logic [31:0] flt_addr;
    logic [7:0]  flt_mst;
    logic [3:0]  flt_priv;
    logic [5:0]  flt_kind;
    logic        reg_en, reg_we, reg_debug;
    logic [OFF_W-1:0] reg_off;
    logic [1:0]  reg_wbits;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mpu_fault_irq #(.ADDR_W(32), .OFF_W(OFF_W)) dut (.*);

    // Behavioural reference model
    logic [1:0]  m_raw, m_en;
    logic [31:0] m_addr, m_st;
    bit          m_clr, m_rec, m_aerr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_raw = 0; m_en = 0; m_addr = 0; m_st = 0;
        end else begin
            m_clr  = reg_en && reg_we && reg_off == 6 && reg_wbits[0];
            m_rec  = flt_valid && !flt_debug && flt_kind != 0 && (m_st[5:0] == 0 || m_clr);
            m_aerr = reg_en && !reg_debug && reg_off > 6;
            if (m_clr) m_st[5:0] = 0;
            if (m_rec) begin
                m_addr = flt_addr;
                m_st   = (32'(flt_mst) << 16) | (32'(flt_priv) << 9) | (32'(flt_ns) << 7) | 32'(flt_kind);
            end
            if (reg_en && reg_we && reg_off == 0) m_raw = m_raw | reg_wbits;
            if (reg_en && reg_we && reg_off == 1) m_raw = m_raw & ~reg_wbits;
            if (reg_en && reg_we && reg_off == 2) m_en  = m_en | reg_wbits;
            if (reg_en && reg_we && reg_off == 3) m_en  = m_en & ~reg_wbits;
            if (m_rec)  m_raw[0] = 1'b1;
            if (m_aerr) m_raw[1] = 1'b1;
        end
    end

    function automatic logic [31:0] model_read(int off);
        case (off)
            0: return 32'(m_raw);
            1: return 32'(m_raw & m_en);
            2, 3: return 32'(m_en);
            4: return m_addr;
            5: return m_st;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        flt_valid = 0; flt_debug = 0; flt_ns = 0; flt_addr = 0; flt_mst = 0;
        flt_priv = 0; flt_kind = 0; reg_en = 0; reg_we = 0; reg_debug = 0;
        reg_off = 0; reg_wbits = 0;
    endtask

    // One clock: irq compared with the model every cycle
    task automatic tick(string req);
        @(negedge clk);
        chk({req, " irq"}, 32'(irq), 32'(|(m_raw & m_en)));
        idle();
    endtask

    task automatic rd(int off, logic [31:0] exp, string req, bit dbg = 0);
        reg_en = 1; reg_we = 0; reg_debug = dbg; reg_off = OFF_W'(off);
        #1;
        chk(req, reg_rdata, exp);
        chk({req, " model"}, reg_rdata, model_read(off));
        tick(req);
    endtask

    task automatic wr(int off, logic [1:0] d, string req);
        reg_en = 1; reg_we = 1; reg_off = OFF_W'(off); reg_wbits = d;
        tick(req);
    endtask

    task automatic set_fault(logic [31:0] a, logic [7:0] m, logic [3:0] p, logic ns,
                             logic dbg, logic [5:0] k);
        flt_valid = 1; flt_addr = a; flt_mst = m; flt_priv = p; flt_ns = ns;
        flt_debug = dbg; flt_kind = k;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) tick("R1");
        rst_n = 1;
        // R1 reset state
        for (int i = 0; i < 7; i++) rd(i, 0, "R1");
        chk("R1 irq low", 32'(irq), 0);

        // R9 enables
        wr(2, 2'b11, "R9");
        rd(2, 3, "R9"); rd(3, 3, "R9");

        // R2 first fault
        set_fault(32'h1234_5400, 8'h5A, 4'hB, 1, 0, 6'b100000);
        tick("R2");
        rd(4, 32'h1234_5400, "R2");
        rd(5, 32'h005A_16A0, "R2");
        rd(0, 1, "R2"); rd(1, 1, "R8");
        chk("R11 irq high", 32'(irq), 1);

        // R3 second fault dropped
        set_fault(32'hDEAD_0000, 8'h11, 4'h1, 0, 0, 6'b000010);
        tick("R3");
        rd(4, 32'h1234_5400, "R3"); rd(5, 32'h005A_16A0, "R3");

        // R8 clear protection status; R3 no new interrupt while held
        wr(1, 2'b01, "R8");
        rd(0, 0, "R8");
        chk("R11 irq cleared", 32'(irq), 0);
        set_fault(32'hDEAD_0400, 8'h22, 4'h2, 0, 0, 6'b010000);
        tick("R3");
        rd(0, 0, "R3");

        // R4 record clear
        wr(6, 2'b00, "R4");
        rd(5, 32'h005A_16A0, "R4");
        wr(6, 2'b01, "R4");
        rd(5, 32'h005A_1680, "R4");
        rd(4, 32'h1234_5400, "R4");
        rd(6, 0, "R4");

        // R6 debug events ignored
        set_fault(32'hFFFF_0000, 8'h77, 4'h7, 1, 1, 6'b111111);
        tick("R6");
        rd(5, 32'h005A_1680, "R6"); rd(4, 32'h1234_5400, "R6"); rd(0, 0, "R6");

        // R2 zero-kind event ignored
        set_fault(32'hABCD_0000, 8'h33, 4'h3, 1, 0, 6'b000000);
        tick("R2");
        rd(5, 32'h005A_1680, "R2"); rd(0, 0, "R2");

        // R2 line fill, secure
        set_fault(32'h0000_0400, 8'h03, 4'h2, 0, 0, 6'b111111);
        tick("R2");
        rd(5, 32'h0003_043F, "R2"); rd(4, 32'h0000_0400, "R2");

        // R12 status clear and capture in one cycle
        wr(6, 2'b01, "R12");
        set_fault(32'h0000_0800, 8'h04, 4'h1, 1, 0, 6'b010010);
        reg_en = 1; reg_we = 1; reg_off = 1; reg_wbits = 2'b01;
        tick("R12");
        rd(0, 1, "R12"); rd(5, 32'h0004_0292, "R12");

        // R5 record clear and capture in one cycle
        set_fault(32'h8000_0000, 8'hFF, 4'hF, 1, 0, 6'b000001);
        reg_en = 1; reg_we = 1; reg_off = 6; reg_wbits = 2'b01;
        tick("R5");
        rd(5, 32'h00FF_1E81, "R5"); rd(4, 32'h8000_0000, "R5");

        // R7 raw set
        wr(1, 2'b11, "R8");
        rd(0, 0, "R8");
        wr(0, 2'b00, "R7");
        rd(0, 0, "R7");
        wr(0, 2'b10, "R7");
        rd(0, 2, "R7"); rd(1, 2, "R8");
        chk("R11 irq from addr bit", 32'(irq), 1);

        // R9 enable clear
        wr(3, 2'b00, "R9");
        rd(2, 3, "R9");
        wr(3, 2'b10, "R9");
        rd(2, 1, "R9"); rd(3, 1, "R9"); rd(1, 0, "R9"); rd(0, 2, "R9");
        chk("R11 irq masked", 32'(irq), 0);

        // R10 unmapped offsets
        wr(1, 2'b10, "R10");
        rd(0, 0, "R10");
        rd(12, 0, "R10", 1);
        rd(0, 0, "R10");
        rd(9, 0, "R10");
        rd(0, 2, "R10");
        wr(1, 2'b10, "R10");
        wr(15, 2'b11, "R10");
        rd(0, 2, "R10");
        wr(2, 2'b10, "R11");
        chk("R11 irq addr enabled", 32'(irq), 1);
        tick("R11");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule